// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer

A 16-bit counter advances on every clock and feeds four identical channels. A channel in capture mode watches its own input pin. The pin passes through a two-stage synchronizer, and on the chosen transition the channel stores the current count. A channel in compare mode holds a target value. When the count reaches that value, the channel raises its flag and drives a one-cycle pulse. Channel 3 can also return the counter to zero, so the counter period can be set by software.

Software reaches the block through a word-wide register bus with one select line and one write strobe. Reads are combinational. Every flag is cleared by writing a 1 to its bit. An optional fast-clear mode wipes all flags whenever the counter address is accessed. The overflow flag, gated by an enable bit, drives the interrupt request. A wrap caused by the channel-3 reset never counts as an overflow.

Top module: `cc_timer4`

## Requirements
- R1: The counter resets to 0x0000 and increments by one each clock, wrapping modulo 2^16. A bus write to address 0 loads the written value in place of the increment.
- R2: Flag register bit 4 (overflow) sets on the clock edge where the counter steps from 0xFFFF to 0x0000 by increment. All flags reset to 0.
- R3: A write to the flag register (address 3) clears each flag whose bit is 1 in the written word. Bits written 0 are left as they were.
- R4: The interrupt output is high while the overflow flag is set and control bit 4 (interrupt enable) is 1.
- R5: With control bit 5 set and channel 3 in compare mode, a channel-3 match loads 0x0000 into the counter on the next edge. When channel 3 holds 0xFFFF, the resulting wrap does not set the overflow flag.
- R6: Every increment overflow sets the overflow flag again after it has been cleared. A set flag never blocks a later overflow.
- R7: With control bit 6 set, any read or write at address 0 clears the whole flag register. With bit 6 clear, such an access leaves the flags alone.
- R8: Control bit n = 0 puts channel n in capture mode. On a selected edge of its pin, the channel stores the count present one cycle after the clock edge that first samples the new pin level, and sets flag bit n.
- R9: The edge register (address 2) holds two bits per channel at bits [2n+1:2n]: 01 rising, 10 falling, 11 either, 00 none. Edges that are not selected cause no capture.
- R10: Control bit n = 1 puts channel n in compare mode. Its register takes bus writes and reads back the written value. When the count equals the register, flag bit n sets and pulse n is high for exactly the next cycle.
- R11: Bus writes to a channel register in capture mode leave its value unchanged.
- R12: Address map: 0 counter, 1 control, 2 edge select, 3 flags, 4 to 7 channels 0 to 3. The counter, flags, control and channel registers read 0 while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| cap_pin | input | 4 | Capture inputs, one per channel |
| irq_o | output | 1 | Overflow interrupt request |
| cmp_pulse_o | output | 4 | One-cycle compare event per channel |

## Verification
The bench targets the wrap from 0xFFFF driven by the channel-3 reset. A design that treats that wrap as a normal overflow would raise the interrupt at the end of every programmed period. It times the capture latency through the synchronizer to the exact cycle, so a missing or extra flop shows up as a stored count that is off by one. It checks that falling edges are ignored under rising-only selection, and that writes to a channel in capture mode are ignored. It compares fast-clear against plain counter reads: a block that always cleared on access, or never did, fails one of the two cases. Flag writes with zero bits catch a register that clears on any write.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int          BUS_AW = 3;
  localparam logic [2:0]  A_CNT  = 3'd0;
  localparam logic [2:0]  A_CTRL = 3'd1;
  localparam logic [2:0]  A_EDGE = 3'd2;
  localparam logic [2:0]  A_FLAG = 3'd3;
  localparam logic [2:0]  A_CH0  = 3'd4;
endpackage

// File: rtl/cct_insync.sv
module cct_insync
  import cct_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  output logic       evt_o
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;
  logic            level;
  logic            prev;

  assign sh_d  = {sh_q[STAGES-1:0], pin_i};
  assign level = sh_q[STAGES-1];
  assign prev  = sh_q[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  always_comb begin
    case (edge_sel_e'(edge_sel_i))
      EDGE_RISE: evt_o = level & ~prev;
      EDGE_FALL: evt_o = ~level & prev;
      EDGE_BOTH: evt_o = level ^ prev;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (load_i)        cnt_d = load_val_i;
    else if (reload_i) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = !load_i && !reload_i && (cnt_q == CNT_MAX);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !reload_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/cct_chan.sv
module cct_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_mode_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_evt_i,
  output logic [CNT_W-1:0] val_o,
  output logic             hit_o,
  output logic             match_o,
  output logic             pulse_o
);
  logic [CNT_W-1:0] val_q;
  logic [CNT_W-1:0] val_d;
  logic             pulse_q;

  assign match_o = cmp_mode_i && (cnt_i == val_q);
  assign hit_o   = match_o || (!cmp_mode_i && cap_evt_i);

  always_comb begin
    val_d = val_q;
    if (cmp_mode_i) begin
      if (wr_en_i) val_d = wr_data_i;
    end else if (cap_evt_i) begin
      val_d = cnt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      val_q   <= val_d;
      pulse_q <= match_o;
    end
  end

  assign val_o   = val_q;
  assign pulse_o = pulse_q;

  // R11
  cap_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_mode_i && !cap_evt_i) |=> $stable(val_q));

  // R8
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_mode_i && cap_evt_i) |=> (val_q == $past(cnt_i)));

  // R10
  pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(cmp_mode_i));
endmodule

// File: rtl/cc_timer4.sv
module cc_timer4
  import cct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [N_CH-1:0]   cap_pin,
  output logic              irq_o,
  output logic [N_CH-1:0]   cmp_pulse_o
);
  localparam int OVF_BIT  = N_CH;
  localparam int FLAG_W   = N_CH + 1;
  localparam int IE_BIT   = N_CH;
  localparam int RST_BIT  = N_CH + 1;
  localparam int FCLR_BIT = N_CH + 2;
  localparam int CTRL_W   = N_CH + 3;
  localparam int EDGE_W   = 2 * N_CH;
  localparam int CH_IW    = $clog2(N_CH);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  // bus decode
  logic              acc_cnt, wr_cnt, wr_ctrl, wr_edge, wr_flag, ch_sel;
  logic [BUS_AW-1:0] ch_off;
  logic [CH_IW-1:0]  ch_idx;
  logic [N_CH-1:0]   ch_wr;

  assign acc_cnt = bus_sel && (bus_addr == A_CNT);
  assign wr_cnt  = acc_cnt && bus_wr;
  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign wr_edge = bus_sel && bus_wr && (bus_addr == A_EDGE);
  assign wr_flag = bus_sel && bus_wr && (bus_addr == A_FLAG);
  assign ch_sel  = bus_addr >= A_CH0;
  assign ch_off  = bus_addr - A_CH0;
  assign ch_idx  = ch_off[CH_IW-1:0];

  // configuration and flag state
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [FLAG_W-1:0] flag_q, flag_d, flag_set, flag_clr;

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             reload;
  logic [N_CH-1:0]  cap_evt, ch_hit, ch_match;
  logic [CNT_W-1:0] ch_val [N_CH];

  always_comb begin
    ctrl_d = ctrl_q;
    edge_d = edge_q;
    if (wr_ctrl) ctrl_d = bus_wdata[CTRL_W-1:0];
    if (wr_edge) edge_d = bus_wdata[EDGE_W-1:0];
  end

  always_comb begin
    flag_set = {wrap, ch_hit};
    flag_clr = '0;
    if (wr_flag)                      flag_clr = flag_clr | bus_wdata[FLAG_W-1:0];
    if (ctrl_q[FCLR_BIT] && acc_cnt)  flag_clr = '1;
    flag_d = (flag_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      edge_q <= '0;
      flag_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      edge_q <= edge_d;
      flag_q <= flag_d;
    end
  end

  assign reload = ctrl_q[RST_BIT] && ch_match[N_CH-1];

  cct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_ni),
    .load_i     (wr_cnt),
    .load_val_i (bus_wdata),
    .reload_i   (reload),
    .cnt_o      (cnt),
    .wrap_o     (wrap)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign ch_wr[g] = bus_sel && bus_wr && ch_sel && (ch_idx == CH_IW'(g));

    cct_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_ni),
      .pin_i      (cap_pin[g]),
      .edge_sel_i (edge_q[2*g +: 2]),
      .evt_o      (cap_evt[g])
    );

    cct_chan #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_ni),
      .cmp_mode_i (ctrl_q[g]),
      .wr_en_i    (ch_wr[g]),
      .wr_data_i  (bus_wdata),
      .cnt_i      (cnt),
      .cap_evt_i  (cap_evt[g]),
      .val_o      (ch_val[g]),
      .hit_o      (ch_hit[g]),
      .match_o    (ch_match[g]),
      .pulse_o    (cmp_pulse_o[g])
    );
  end

  always_comb begin
    case (bus_addr)
      A_CNT:   bus_rdata = cnt;
      A_CTRL:  bus_rdata = CNT_W'(ctrl_q);
      A_EDGE:  bus_rdata = CNT_W'(edge_q);
      A_FLAG:  bus_rdata = CNT_W'(flag_q);
      default: bus_rdata = ch_val[ch_idx];
    endcase
  end

  assign irq_o = flag_q[OVF_BIT] && ctrl_q[IE_BIT];

  // R2
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flag_q[OVF_BIT]) |-> ($past(cnt) == CNT_MAX));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q[RST_BIT] && ctrl_q[N_CH-1] && ch_val[N_CH-1] == CNT_MAX &&
     cnt == CNT_MAX && !wr_cnt) |=> !$rose(flag_q[OVF_BIT]));

  // R7
  fast_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q[FCLR_BIT] && acc_cnt && !wrap) |=> !flag_q[OVF_BIT]);
endmodule

// File: tb/cc_timer4_tb_top.sv
module cc_timer4_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [1:0]  ch;
    logic [15:0] start;
    logic [15:0] cmp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{ch: 2'd0, start: 16'h0100, cmp: 16'h0105},
    '{ch: 2'd1, start: 16'h2000, cmp: 16'h2000},
    '{ch: 2'd2, start: 16'hFFF8, cmp: 16'h0002},
    '{ch: 2'd3, start: 16'h0040, cmp: 16'h004C},
    '{ch: 2'd0, start: 16'h7FFE, cmp: 16'h7FFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  cap_pin = '0;
  logic        irq_o;
  logic [3:0]  cmp_pulse_o;

  int n_cmp = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_timer4 dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .cap_pin     (cap_pin),
    .irq_o       (irq_o),
    .cmp_pulse_o (cmp_pulse_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] d;
    vec_t        v;
    logic [15:0] k;
    int          first;
    int          npulse;

    // R12: reset state of registers and outputs
    brd(3'd0, d); chk("R12 counter in reset", d, 16'h0000);
    brd(3'd3, d); chk("R12 flags in reset", d, 16'h0000);
    brd(3'd1, d); chk("R12 control in reset", d, 16'h0000);
    brd(3'd4, d); chk("R12 channel0 in reset", d, 16'h0000);
    chk("R4 irq in reset", {15'd0, irq_o}, 16'h0000);
    chk("R10 pulses in reset", {12'd0, cmp_pulse_o}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: load then count
    bwr(3'd0, 16'h1234);
    brd(3'd0, d); chk("R1 count after load", d, 16'h1235);
    brd(3'd0, d); chk("R1 count increments", d, 16'h1236);

    // R10: compare vector table, all channels in compare mode
    bwr(3'd1, 16'h000F);
    for (int i = 0; i < 5; i++) begin
      v = VECS[i];
      bwr(3'd4 + {1'b0, v.ch}, v.cmp);
      brd(3'd4 + {1'b0, v.ch}, d);
      chk("R10 compare register readback", d, v.cmp);
      bwr(3'd0, v.start);
      k = v.cmp - v.start;
      first = -1;
      npulse = 0;
      for (int j = 1; j <= int'(k) + 3; j++) begin
        @(negedge clk); #1;
        if (cmp_pulse_o[v.ch]) begin
          npulse++;
          if (first < 0) first = j;
        end
      end
      chk("R10 pulse cycle", 16'(first), 16'(int'(k) + 1));
      chk("R10 pulse width", 16'(npulse), 16'd1);
      brd(3'd3, d);
      chk("R10 channel flag", d & (16'h1 << v.ch), 16'h1 << v.ch);
    end

    // R2 R4: overflow sets flag and interrupt
    bwr(3'd1, 16'h001F);
    bwr(3'd3, 16'h001F);
    bwr(3'd0, 16'hFFFD);
    @(negedge clk); @(negedge clk); #1;
    chk("R4 irq before wrap", {15'd0, irq_o}, 16'h0000);
    @(negedge clk); #1;
    chk("R2 R4 irq after wrap", {15'd0, irq_o}, 16'h0001);

    // R3: write-one-to-clear
    bwr(3'd3, 16'h000F);
    brd(3'd3, d); chk("R3 zero bit keeps flag", d & 16'h0010, 16'h0010);
    bwr(3'd3, 16'h0010);
    brd(3'd3, d); chk("R3 one bit clears flag", d & 16'h0010, 16'h0000);
    chk("R4 irq follows flag", {15'd0, irq_o}, 16'h0000);

    // R6: later overflow sets the flag again
    bwr(3'd0, 16'hFFFF);
    brd(3'd3, d); chk("R6 second overflow", d & 16'h0010, 16'h0010);

    // R5: channel-3 reset at 0xFFFF suppresses overflow
    bwr(3'd7, 16'hFFFF);
    bwr(3'd1, 16'h003F);
    bwr(3'd3, 16'h001F);
    bwr(3'd0, 16'hFFFD);
    repeat (4) @(negedge clk);
    brd(3'd3, d);
    chk("R5 no overflow on reset wrap", d & 16'h0010, 16'h0000);
    chk("R5 channel3 flag on reset wrap", d & 16'h0008, 16'h0008);
    chk("R5 irq stays low", {15'd0, irq_o}, 16'h0000);

    // R5: reload mid-range
    bwr(3'd7, 16'h0010);
    bwr(3'd0, 16'h000F);
    brd(3'd0, d); chk("R5 count reaches compare", d, 16'h0010);
    brd(3'd0, d); chk("R5 count reloaded to zero", d, 16'h0000);

    // R7: counter access without fast clear keeps flags
    bwr(3'd1, 16'h001F);
    bwr(3'd0, 16'hFFFE);
    repeat (2) @(negedge clk);
    brd(3'd0, d);
    brd(3'd3, d); chk("R7 plain access keeps flag", d & 16'h0010, 16'h0010);

    // R7: fast clear on counter access
    bwr(3'd1, 16'h005F);
    bwr(3'd0, 16'hFFFE);
    @(negedge clk); @(negedge clk); #1;
    chk("R7 irq set before access", {15'd0, irq_o}, 16'h0001);
    brd(3'd3, d); chk("R7 flag before access", d & 16'h0010, 16'h0010);
    brd(3'd0, d);
    brd(3'd3, d); chk("R7 fast clear on read", d & 16'h0010, 16'h0000);
    chk("R7 irq after fast clear", {15'd0, irq_o}, 16'h0000);

    // R11: channel 1 in capture mode ignores writes
    bwr(3'd1, 16'h001D);
    bwr(3'd2, 16'h0004);
    bwr(3'd3, 16'h001F);
    bwr(3'd5, 16'hABCD);
    brd(3'd5, d); chk("R11 capture write ignored", d, 16'h2000);

    // R8: rising capture timing
    bwr(3'd0, 16'h1000);
    @(negedge clk); @(negedge clk);
    cap_pin[1] = 1'b1;
    repeat (5) @(negedge clk);
    brd(3'd5, d); chk("R8 rising capture value", d, 16'h1004);
    brd(3'd3, d); chk("R8 capture flag", d & 16'h0002, 16'h0002);

    // R9: falling edge ignored under rising-only selection
    cap_pin[1] = 1'b0;
    repeat (6) @(negedge clk);
    brd(3'd5, d); chk("R9 falling edge ignored", d, 16'h1004);

    // R9: either-edge selection, rising then falling
    bwr(3'd2, 16'h000C);
    bwr(3'd0, 16'h3000);
    @(negedge clk);
    cap_pin[1] = 1'b1;
    repeat (5) @(negedge clk);
    brd(3'd5, d); chk("R9 either edge rising", d, 16'h3003);
    bwr(3'd0, 16'h5000);
    @(negedge clk); @(negedge clk);
    cap_pin[1] = 1'b0;
    repeat (5) @(negedge clk);
    brd(3'd5, d); chk("R9 either edge falling", d, 16'h5004);

    // R9: selection 00 disables capture
    bwr(3'd2, 16'h0000);
    cap_pin[1] = 1'b1;
    repeat (6) @(negedge clk);
    brd(3'd5, d); chk("R9 no edge selected", d, 16'h5004);

    summary();
  end
endmodule